// File: doc/BRIEF.md
# Nibble-Window Comb Multiplier for Binary Fields

This block forms the carry-less product of two elements of GF(2^m) in polynomial basis. Each element is presented as a vector of n = ceil(m/8) bytes. The result is the unreduced polynomial product, 2n bytes wide, and a separate reduction stage would normally follow it. With the default field size of 163 bits, each operand is 21 bytes and the product is 42 bytes.

A request is made by pulsing `start` while the unit is idle, with both operands on the parallel input ports. The unit then builds a 16-entry table holding the products of the second operand with every polynomial of degree below four. Next it scans the first operand one byte per cycle in two passes. The first pass takes the upper nibble of each byte and the second pass takes the lower nibble. Between the passes there is a single 4-bit left shift of the partial result.

Partial sums are kept in a sliding window of n+1 bytes. Each time a byte of the result leaves the window it is final for that pass. The unit raises `done` for one cycle when the full product is on `product`.

Top module: `gf2_comb_multiplier`

## Requirements
- R1: When `done` is high, `product` equals the carry-less (XOR-accumulated) product of the two operands. Operand bit i is the coefficient of z^i, byte k of an operand covers bits 8k..8k+7, and both operands must be zero above bit m-1.
- R2: `done` is high for exactly one cycle per accepted request. No other `done` pulse occurs.
- R3: `done` rises exactly 2n+18 clock cycles after the rising edge at which a request is accepted, which is 60 cycles for the default field.
- R4: `busy` is high from the edge that accepts a request until the edge that raises `done`, and it is low while `done` is high.
- R5: A `start` pulse while `busy` is high has no effect. The running request still yields its own product with its own timing, and no additional `done` follows.
- R6: Operands are captured at the accepting edge. Changes on `opA` or `opB` afterwards do not alter the result.
- R7: While the unit is idle and no request is accepted, `product` keeps its last value, whatever the operand ports do.
- R8: After reset, `busy` and `done` are low and `product` is all zeros.
- R9: Corner operands give the exact product. A zero operand gives zero, the constant 1 gives the other operand unchanged, and two all-ones m-bit operands give the full-degree product whose top coefficient is at z^(2m-2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled only while idle |
| opA | input | 8*n | First operand; its nibbles select table entries |
| opB | input | 8*n | Second operand; used to build the multiple table |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse when `product` is valid |
| product | output | 16*n | Unreduced carry-less product |

## Verification
On every cycle, the assertions check the handshake timing. They confirm that `done` is a single-cycle pulse, that it never coincides with `busy`, that acceptance raises `busy`, and that the fixed latency from acceptance to `done` holds. They also confirm that `product` stays still while the unit is idle. The arithmetic itself can only be shown by the bench's scenarios. The bench compares each product against a bit-serial shift-and-XOR reference for random operands and for the zero, identity and full-degree corners. Its scenarios also show that operand changes after acceptance, or a stray `start` during a run, leave the result and its timing untouched.

// File: rtl/gf2_comb_pkg.sv
package gf2_comb_pkg;

  // Strobes from control to datapath and table, one set per cycle.
  typedef struct packed {
    logic       loadOps;   // capture operands, clear window
    logic       tableWr;   // write one table entry
    logic [3:0] tableIdx;  // entry being written
    logic       hiAcc;     // upper-nibble accumulation step
    logic       shiftAcc;  // multiply partial result by z^4
    logic       loAcc;     // lower-nibble accumulation step
    logic       fold;      // merge window into upper result half
  } combStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TABLE,
    ST_HI,
    ST_SHIFT,
    ST_LO,
    ST_FOLD
  } combState_t;

endpackage

// File: rtl/gf2_comb_ctrl.sv
module gf2_comb_ctrl
  import gf2_comb_pkg::*;
#(
  parameter int BYTES = 21
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  output combStrobe_t           strb,
  output logic [IDXW-1:0]       byteIdx,
  output logic                  busy,
  output logic                  done
);

  localparam int IDXW = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int CNTW = (IDXW > 4) ? IDXW : 4;
  localparam logic [CNTW-1:0] LAST_BYTE  = CNTW'(BYTES - 1);
  localparam logic [CNTW-1:0] LAST_ENTRY = CNTW'(15);

  combState_t      state;
  logic [CNTW-1:0] cnt;

  always_comb begin
    strb          = '0;
    strb.loadOps  = (state == ST_IDLE) && start;
    strb.tableWr  = (state == ST_TABLE);
    strb.tableIdx = cnt[3:0];
    strb.hiAcc    = (state == ST_HI);
    strb.shiftAcc = (state == ST_SHIFT);
    strb.loAcc    = (state == ST_LO);
    strb.fold     = (state == ST_FOLD);
  end

  assign byteIdx = cnt[IDXW-1:0];
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_FOLD);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_TABLE;
            cnt   <= '0;
          end
        end
        ST_TABLE: begin
          if (cnt == LAST_ENTRY) begin
            state <= ST_HI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HI: begin
          if (cnt == LAST_BYTE) begin
            state <= ST_SHIFT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          state <= ST_LO;
          cnt   <= '0;
        end
        ST_LO: begin
          if (cnt == LAST_BYTE) begin
            state <= ST_FOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FOLD: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gf2_comb_table.sv
module gf2_comb_table #(
  parameter int BYTES = 21
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadOps,
  input  logic [8*BYTES-1:0]    opB,
  input  logic                  tableWr,
  input  logic [3:0]            wrIdx,
  input  logic [3:0]            rdIdx,
  output logic [ENTW-1:0]       rdEntry
);

  localparam int ENTW = 8 * (BYTES + 1);

  logic [8*BYTES-1:0] bReg;
  logic [ENTW-1:0]    bExt;
  logic [ENTW-1:0]    tbl [16];

  assign bExt = {8'h00, bReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        bReg <= '0;
    else if (loadOps) bReg <= opB;
  end

  // Entry e is built from entry e/2 shifted by one place, plus b when e is
  // odd. Writing in ascending order guarantees the parent is ready.
  for (genvar e = 0; e < 16; e++) begin : g_ent
    if (e == 0) begin : g_zero
      assign tbl[e] = '0;
    end else begin : g_reg
      localparam bit ODD = (e % 2) == 1;
      logic [ENTW-1:0] entReg;
      logic [ENTW-1:0] nxt;
      assign nxt = (tbl[e/2] << 1) ^ (ODD ? bExt : '0);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                           entReg <= '0;
        else if (tableWr && wrIdx == 4'(e))  entReg <= nxt;
      end
      assign tbl[e] = entReg;
    end
  end

  assign rdEntry = tbl[rdIdx];

endmodule

// File: rtl/gf2_comb_dp.sv
module gf2_comb_dp
  import gf2_comb_pkg::*;
#(
  parameter int BYTES = 21
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  combStrobe_t           strb,
  input  logic [IDXW-1:0]       byteIdx,
  input  logic [8*BYTES-1:0]    opA,
  output logic [3:0]            nibSel,
  input  logic [ENTW-1:0]       entry,
  output logic [16*BYTES-1:0]   product
);

  localparam int IDXW  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int ENTW  = 8 * (BYTES + 1);
  localparam int HALFW = 8 * BYTES;

  logic [HALFW-1:0]   aReg;
  logic [ENTW-1:0]    win;
  logic [ENTW-1:0]    sum;
  logic [7:0]         aByte;
  logic [16*BYTES-1:0] res;

  assign aByte  = aReg[int'(byteIdx)*8 +: 8];
  assign nibSel = strb.hiAcc ? aByte[7:4] : aByte[3:0];
  assign sum    = win ^ entry;
  assign product = res;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      win  <= '0;
      res  <= '0;
    end else begin
      if (strb.loadOps) begin
        aReg <= opA;
        win  <= '0;
      end
      if (strb.hiAcc) begin
        // lowest window byte is final for this pass
        res[int'(byteIdx)*8 +: 8] <= sum[7:0];
        win <= sum >> 8;
      end
      if (strb.shiftAcc) begin
        res <= {win[HALFW-1:0], res[HALFW-1:0]} << 4;
        win <= '0;
      end
      if (strb.loAcc) begin
        res[int'(byteIdx)*8 +: 8] <= res[int'(byteIdx)*8 +: 8] ^ sum[7:0];
        win <= sum >> 8;
      end
      if (strb.fold) begin
        res[16*BYTES-1:HALFW] <= res[16*BYTES-1:HALFW] ^ win[HALFW-1:0];
      end
    end
  end

endmodule

// File: rtl/gf2_comb_multiplier.sv
module gf2_comb_multiplier
  import gf2_comb_pkg::*;
#(
  parameter int FIELD_BITS = 163
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [8*BYTES-1:0]        opA,
  input  logic [8*BYTES-1:0]        opB,
  output logic                      busy,
  output logic                      done,
  output logic [16*BYTES-1:0]       product
);

  localparam int BYTES = (FIELD_BITS + 7) / 8;
  localparam int IDXW  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int ENTW  = 8 * (BYTES + 1);

  combStrobe_t       strb;
  logic [IDXW-1:0]   byteIdx;
  logic [3:0]        nibSel;
  logic [ENTW-1:0]   entry;

  gf2_comb_ctrl #(.BYTES(BYTES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strb    (strb),
    .byteIdx (byteIdx),
    .busy    (busy),
    .done    (done)
  );

  gf2_comb_table #(.BYTES(BYTES)) u_table (
    .clk     (clk),
    .rstN    (rstN),
    .loadOps (strb.loadOps),
    .opB     (opB),
    .tableWr (strb.tableWr),
    .wrIdx   (strb.tableIdx),
    .rdIdx   (nibSel),
    .rdEntry (entry)
  );

  gf2_comb_dp #(.BYTES(BYTES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .byteIdx (byteIdx),
    .opA     (opA),
    .nibSel  (nibSel),
    .entry   (entry),
    .product (product)
  );

endmodule

// File: rtl/gf2_comb_chk.sv
module gf2_comb_chk #(
  parameter int FIELD_BITS = 163
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic [16*BYTES-1:0]        product
);

  localparam int BYTES = (FIELD_BITS + 7) / 8;
  localparam int LAT   = 2 * BYTES + 18;
  localparam int LATW  = $clog2(LAT + 1) + 1;

  logic [LATW-1:0] latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                latCnt <= '0;
    else if (start && !busy)  latCnt <= '0;
    else if (busy)            latCnt <= latCnt + 1'b1;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == LATW'(LAT)));

  // R7
  hold_product_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!busy && !done));

endmodule

bind gf2_comb_multiplier gf2_comb_chk #(.FIELD_BITS(FIELD_BITS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/test_gf2_comb_multiplier.sv
module test_gf2_comb_multiplier;

  localparam int CLK_PERIOD = 10;
  localparam int FIELD_BITS = 163;
  localparam int BYTES      = (FIELD_BITS + 7) / 8;
  localparam int OW         = 8 * BYTES;
  localparam int PW         = 16 * BYTES;
  localparam int LAT        = 2 * BYTES + 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [OW-1:0] opA = '0;
  logic [OW-1:0] opB = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [PW-1:0] expQ [$];
  int            accQ [$];
  string         tagQ [$];
  logic          prevDone = 1'b0;

  gf2_comb_multiplier #(.FIELD_BITS(FIELD_BITS)) i_gf2_comb_multiplier (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opA     (opA),
    .opB     (opB),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] refMul(input logic [OW-1:0] a,
                                           input logic [OW-1:0] b);
    logic [PW-1:0] r = '0;
    for (int i = 0; i < FIELD_BITS; i++)
      if (a[i]) r = r ^ (PW'(b) << i);
    return r;
  endfunction

  function automatic logic [OW-1:0] randElem();
    logic [OW-1:0] v = '0;
    for (int i = 0; i < FIELD_BITS; i++) v[i] = 1'($urandom % 2);
    return v;
  endfunction

  // Driver: pushes the expected product, then issues the request and
  // scrambles the operand ports once the request is taken (R6).
  task automatic runOp(input logic [OW-1:0] a, input logic [OW-1:0] b,
                       input string tag);
    while (busy) @(negedge clk);
    opA   = a;
    opB   = b;
    start = 1'b1;
    expQ.push_back(refMul(a, b));
    tagQ.push_back(tag);
    @(negedge clk);
    accQ.push_back(cyc);
    start = 1'b0;
    chk(busy == 1'b1, "R4 busy after accept", PW'(busy), PW'(1));
    opA = randElem();
    opB = randElem();
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on each done pulse.
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected done", PW'(1), PW'(0));
        end else begin
          logic [PW-1:0] e;
          int            a;
          string         t;
          e = expQ.pop_front();
          a = accQ.pop_front();
          t = tagQ.pop_front();
          chk(product == e, t, product, e);
          chk(cyc - a == LAT, "R3 latency", PW'(cyc - a), PW'(LAT));
          chk(busy == 1'b0, "R4 busy low at done", PW'(busy), PW'(0));
        end
      end
      if (prevDone)
        chk(done == 1'b0, "R2 single-cycle done", PW'(done), PW'(0));
      prevDone <= done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [OW-1:0] ones;
    logic [OW-1:0] x;
    logic [PW-1:0] held;
    ones = '0;
    for (int i = 0; i < FIELD_BITS; i++) ones[i] = 1'b1;

    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8 busy in reset", PW'(busy), PW'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R8 busy after reset", PW'(busy), PW'(0));
    chk(done == 1'b0, "R8 done after reset", PW'(done), PW'(0));
    chk(product == '0, "R8 product after reset", product, '0);

    // R9 corners
    x = randElem();
    runOp('0, x, "R9 zero operand");
    waitIdle();
    runOp(OW'(1), x, "R9 identity");
    waitIdle();
    runOp(x, OW'(1), "R9 identity swapped");
    waitIdle();
    runOp(ones, ones, "R9 all ones");
    waitIdle();
    chk(product[2*FIELD_BITS-2] == 1'b1, "R9 top coefficient",
        PW'(product[2*FIELD_BITS-2]), PW'(1));

    // R1 random operands, some issued back to back
    for (int k = 0; k < 16; k++) begin
      runOp(randElem(), randElem(), "R1 random product");
      if (k % 2 == 0) waitIdle();
    end
    waitIdle();
    runOp(OW'(8'hF0), ones, "R1 single high nibble");
    waitIdle();

    // R5 stray start during a run, with different operands
    runOp(randElem(), randElem(), "R5 product with stray start");
    repeat (7) @(negedge clk);
    chk(busy == 1'b1, "R5 still busy", PW'(busy), PW'(1));
    opA   = randElem();
    opB   = randElem();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (LAT + 10) @(negedge clk);
    chk(expQ.size() == 0, "R5 no extra done", PW'(expQ.size()), PW'(0));

    // R6 explicit: operands change every cycle during the run
    runOp(randElem(), randElem(), "R6 captured operands");
    repeat (LAT / 2) begin
      opA = randElem();
      opB = randElem();
      @(negedge clk);
    end
    waitIdle();

    // R7 product held while idle
    held = product;
    for (int k = 0; k < 20; k++) begin
      opA = randElem();
      opB = randElem();
      @(negedge clk);
    end
    chk(product == held, "R7 product held", product, held);

    chk(expQ.size() == 0, "R2 one done per request", PW'(expQ.size()), PW'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule